// File: doc/BRIEF.md
# Engine Result to Frame-Buffer Arbiter

This block collects finished pixels from a pool of iteration engines and stores them in a 640x480 frame buffer. The buffer holds one 12-bit 4:4:4 colour word per pixel. Each engine raises its done flag with three items held steady: an iteration count, the row of the pixel and its column. The arbiter grants one finished engine per clock in round-robin order. It turns that engine's row and column into a linear buffer address and maps the count to a colour word. Then it issues one write on the buffer's write port and, in the same cycle, a one-cycle acknowledge to that engine. The buffer's second port is left to the display readout, which is outside this block.

The engine side is a valid/ready pair per engine. `eng_done` is valid and `eng_ack` is a one-cycle ready pulse. The back-pressure rules are these. An engine keeps its done flag high and its count, row and column stable until it sees its acknowledge. After that it must drop done by the next clock edge. The arbiter ignores an engine's done flag during the cycle in which that engine's acknowledge is high. The write port has no back-pressure: the buffer accepts a write every cycle.

Top module: `fb_result_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `fb_we` and every bit of `eng_ack` are low.
- R2: In any cycle at most one bit of `eng_ack` is high. `fb_we` is high exactly when one bit of `eng_ack` is high, and that bit names the engine whose result is being written.
- R3: The write address equals row*640 + column of the serviced engine. Row 0 column 0 maps to address 0, and row 479 column 639 maps to 307199.
- R4: For a count below MAX_ITER, the colour word is red in bits [11:8], taken from count bits [3:0]. Green is in bits [7:4], from count bits [5:2]. Blue is in bits [3:0], from count bits [7:4].
- R5: A count equal to or above MAX_ITER (a point that never escaped) is written as 12'h000.
- R6: A count below MAX_ITER whose R4 mapping gives 12'h000 is written as 12'h001, so an escaped point is never black.
- R7: Round-robin order: the search for a winner starts at the engine after the last one granted, goes upward and wraps. After reset the search starts at engine 0.
- R8: An engine whose done flag is high, and is not being ignored, at a rising edge with no other winner gets its write and acknowledge in the cycle that follows that edge.
- R9: An engine's done flag is ignored during its acknowledge cycle. Each result is therefore written exactly once, even though done is still high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_done | input | N_ENG | Per-engine result valid |
| eng_iter | input | N_ENG*CNT_W | Per-engine iteration count, engine i at [i*CNT_W +: CNT_W] |
| eng_row | input | N_ENG*ROW_W | Per-engine pixel row, engine i at [i*ROW_W +: ROW_W] |
| eng_col | input | N_ENG*COL_W | Per-engine pixel column, engine i at [i*COL_W +: COL_W] |
| eng_ack | output | N_ENG | One-cycle acknowledge (ready) pulse per engine |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_addr | output | 19 | Frame-buffer linear write address |
| fb_wdata | output | 12 | Frame-buffer colour word {R,G,B} |

## Verification
A corrupt round-robin pointer appears within a couple of cycles as an acknowledge order different from the rotation that R7 predicts. A stale or missing mask appears one cycle after an acknowledge: the same engine is acknowledged again and its pixel is written twice. A fault in the address adder or the colour map appears on the very write it affects, as a wrong address or a wrong data word. The bench therefore checks every write against the job it expects and sweeps every 8-bit count value.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int H_RES    = 640;
  localparam int V_RES    = 480;
  localparam int FB_DEPTH = H_RES * V_RES;
  localparam int FB_AW    = $clog2(FB_DEPTH);
  localparam int CH_W     = 4;
  localparam int PIX_W    = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] blu;
  } rgb444_t;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_REQ = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W:0]   cand;

  // scan upward from the pointer, wrapping, first requester wins
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    cand    = '0;
    for (int i = 0; i < N_REQ; i++) begin
      cand = {1'b0, ptr_q} + (IDX_W+1)'(i);
      if (cand >= (IDX_W+1)'(N_REQ)) cand = cand - (IDX_W+1)'(N_REQ);
      if (!gnt_vld && req[cand]) begin
        gnt_vld = 1'b1;
        gnt_idx = cand[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (gnt_vld)
      ptr_q <= (gnt_idx == IDX_W'(N_REQ-1)) ? '0 : gnt_idx + 1'b1;
  end

  // R7
  gnt_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_idx]);
  // R7
  idle_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !gnt_vld);
endmodule

// File: rtl/pix_addr.sv
module pix_addr #(
  parameter int ROW_W = 9,
  parameter int COL_W = 10,
  parameter int AW    = 19
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [AW-1:0]    addr
);
  // row*640 = row*512 + row*128
  logic [AW-1:0] row_x512, row_x128;
  assign row_x512 = AW'(row) << 9;
  assign row_x128 = AW'(row) << 7;
  assign addr     = row_x512 + row_x128 + AW'(col);
endmodule

// File: rtl/iter_color.sv
module iter_color
  import fb_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MAX_ITER = 200
) (
  input  logic [CNT_W-1:0] iter,
  output rgb444_t          color
);
  rgb444_t raw;
  logic    escaped;

  assign raw.red = iter[3:0];
  assign raw.grn = iter[5:2];
  assign raw.blu = iter[7:4];
  assign escaped = (32'(iter) < MAX_ITER);

  always_comb begin
    if (!escaped)           color = '0;
    else if (raw == '0)     color = rgb444_t'(PIX_W'(1));
    else                    color = raw;
  end
endmodule

// File: rtl/fb_result_writer.sv
module fb_result_writer
  import fb_pkg::*;
#(
  parameter int N_ENG    = 4,
  parameter int CNT_W    = 8,
  parameter int MAX_ITER = 200,
  parameter int ROW_W    = 9,
  parameter int COL_W    = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ENG-1:0]       eng_done,
  input  logic [N_ENG*CNT_W-1:0] eng_iter,
  input  logic [N_ENG*ROW_W-1:0] eng_row,
  input  logic [N_ENG*COL_W-1:0] eng_col,
  output logic [N_ENG-1:0]       eng_ack,
  output logic                   fb_we,
  output logic [FB_AW-1:0]       fb_addr,
  output logic [PIX_W-1:0]       fb_wdata
);
  localparam int IDX_W = (N_ENG > 1) ? $clog2(N_ENG) : 1;

  logic [N_ENG-1:0] req, ack_q;
  logic             gnt_vld, we_q;
  logic [IDX_W-1:0] gnt_idx;
  logic [CNT_W-1:0] sel_iter;
  logic [ROW_W-1:0] sel_row;
  logic [COL_W-1:0] sel_col;
  logic [FB_AW-1:0] addr_c, addr_q;
  rgb444_t          color_c, data_q;

  // an engine acked this cycle still shows done; skip it
  assign req = eng_done & ~ack_q;

  rr_pick #(.N_REQ(N_ENG), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(req),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  always_comb begin
    sel_iter = eng_iter[gnt_idx*CNT_W +: CNT_W];
    sel_row  = eng_row [gnt_idx*ROW_W +: ROW_W];
    sel_col  = eng_col [gnt_idx*COL_W +: COL_W];
  end

  pix_addr #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(FB_AW)) u_addr (
    .row(sel_row), .col(sel_col), .addr(addr_c)
  );

  iter_color #(.CNT_W(CNT_W), .MAX_ITER(MAX_ITER)) u_color (
    .iter(sel_iter), .color(color_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      ack_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= gnt_vld;
      ack_q  <= gnt_vld ? (N_ENG'(1) << gnt_idx) : '0;
      addr_q <= addr_c;
      data_q <= color_c;
    end
  end

  assign eng_ack  = ack_q;
  assign fb_we    = we_q;
  assign fb_addr  = addr_q;
  assign fb_wdata = data_q;

  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_ack));
  // R2
  we_ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we == (eng_ack != '0));
  // R8
  serviced_was_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> ((eng_ack & $past(eng_done)) != '0));
  // R9
  no_double_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ack != '0) |=> ((eng_ack & $past(eng_ack)) == '0));
endmodule

// File: tb/sim_fb_result_writer.sv
`timescale 1ns/1ps
module sim_fb_result_writer;
  localparam int N = 4, CW = 8, RW = 9, KW = 10, MAXI = 200, NJ = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    done_v = '0;
  logic [N*CW-1:0] iter_v = '0;
  logic [N*RW-1:0] row_v  = '0;
  logic [N*KW-1:0] col_v  = '0;
  logic [N-1:0]    eng_ack;
  logic            fb_we;
  logic [18:0]     fb_addr;
  logic [11:0]     fb_wdata;

  always #2 clk = ~clk;

  fb_result_writer #(.N_ENG(N), .CNT_W(CW), .MAX_ITER(MAXI), .ROW_W(RW), .COL_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .eng_done(done_v), .eng_iter(iter_v),
    .eng_row(row_v), .eng_col(col_v), .eng_ack(eng_ack),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata)
  );

  int nchk = 0, nbad = 0, glen = 0, next_job = 0, wtotal = 0;
  int job_of [N];
  bit pend [N];
  int written [NJ];
  int glog [NJ];
  bit auto_arm = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int j_iter(int k); return k % 256; endfunction
  function automatic int j_row(int k);
    if (k == 0 || k == 3) return 479;
    if (k == 1 || k == 2) return 0;
    return (k * 37) % 480;
  endfunction
  function automatic int j_col(int k);
    if (k == 0 || k == 2) return 639;
    if (k == 1 || k == 3) return 0;
    return (k * 113) % 640;
  endfunction
  function automatic int exp_color(int it);
    int v;
    if (it >= MAXI) return 0;
    v = (it % 16) * 256 + ((it / 4) % 16) * 16 + (it / 16) % 16;
    return (v == 0) ? 1 : v;
  endfunction

  task automatic arm(input int e, input int k);
    job_of[e] = k;
    iter_v[e*CW +: CW] = CW'(j_iter(k));
    row_v[e*RW +: RW]  = RW'(j_row(k));
    col_v[e*KW +: KW]  = KW'(j_col(k));
    done_v[e] = 1'b1;
  endtask

  task automatic step();
    bit newp [N];
    int e, k, it;
    @(negedge clk);
    for (int i = 0; i < N; i++) newp[i] = 0;
    if (fb_we) begin
      chk("R2 ack count with write", $countones(eng_ack), 1);
      e = 0;
      for (int i = 0; i < N; i++) if (eng_ack[i]) e = i;
      chk("R9 acked engine was pending-free and done", int'(done_v[e] && !pend[e]), 1);
      k = job_of[e];
      it = j_iter(k);
      chk("R3 address", int'(fb_addr), j_row(k) * 640 + j_col(k));
      if (it >= MAXI) chk("R5 black for non-escaped", int'(fb_wdata), 0);
      else if (exp_color(it) == 1 && it % 256 == 0) chk("R6 non-black floor", int'(fb_wdata), 1);
      else chk("R4 colour map", int'(fb_wdata), exp_color(it));
      written[k]++;
      wtotal++;
      glog[glen] = e;
      glen++;
      newp[e] = 1;
    end else begin
      chk("R2 no ack without write", int'(eng_ack), 0);
    end
    for (int i = 0; i < N; i++) if (pend[i]) begin done_v[i] = 1'b0; pend[i] = 0; end
    for (int i = 0; i < N; i++) if (newp[i]) pend[i] = 1;
    if (auto_arm)
      for (int i = 0; i < N; i++)
        if (!done_v[i] && next_job < NJ) begin arm(i, next_job); next_job++; end
  endtask

  initial begin
    #(4 * 200000);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", wtotal, NJ);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin job_of[i] = 0; pend[i] = 0; end
    for (int k = 0; k < NJ; k++) written[k] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 we in reset", int'(fb_we), 0);
    chk("R1 ack in reset", int'(eng_ack), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 we after reset", int'(fb_we), 0);
    chk("R1 ack after reset", int'(eng_ack), 0);

    // R8/R7: engines 2 and 0 together, pointer starts at 0
    arm(2, 1); arm(0, 0);
    step();
    chk("R8 write one cycle after done", glen, 1);
    chk("R7 first winner after reset", glog[0], 0);
    step();
    chk("R7 second winner", glog[1], 2);
    step(); step();
    chk("R9 no extra writes in burst A", glen, 2);

    // R7: after engine 2, search starts at 3 then wraps
    arm(0, 2); arm(1, 3); arm(3, 4);
    step(); step(); step();
    chk("R7 wrap order 1st", glog[2], 3);
    chk("R7 wrap order 2nd", glog[3], 0);
    chk("R7 wrap order 3rd", glog[4], 1);
    step(); step();
    chk("R9 no extra writes in burst B", glen, 5);

    // sweep every count value across all engines
    next_job = 5;
    auto_arm = 1;
    for (int c = 0; c < 5000 && wtotal < NJ; c++) step();
    auto_arm = 0;
    step(); step();
    chk("R9 total writes", wtotal, NJ);
    for (int k = 0; k < NJ; k++)
      if (written[k] != 1) chk("R9 job written once", written[k], 1);
    nchk++;

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule